// File: doc/BRIEF.md
# Sequential Shift-Add Multiplier

This block forms the full 64-bit unsigned product of two 32-bit operands with a single 32-bit adder. It reuses that adder over 32 clock iterations. The multiplier operand sits in the lower half of one double-width product register. As each iteration consumes a multiplier bit, the partial product grows into the space that bit leaves behind. There is no separate multiplier shift register and no 64-bit adder.

A client places both operands on the inputs and raises `start_i` for one cycle while the block is idle. `busy_o` is then high for exactly 32 cycles. `done_o` pulses once, and `product_o` keeps the result until the next accepted start. Each iteration looks at the lowest bit of the product register. If that bit is one, the latched multiplicand is added to the upper half. The register then moves one place toward its low end, and the adder's carry-out enters at the top bit.

Top module: `mul_seq_shiftadd`

## Requirements
- R1: After reset, `busy_o` and `done_o` are 0 and `product_o` is 0.
- R2: A `start_i` sampled high at a rising edge while `busy_o` is low latches both operands, and `busy_o` is 1 from the next cycle.
- R3: `busy_o` stays high for exactly 32 consecutive cycles. In the cycle after the last of them, `busy_o` is 0 and `done_o` is 1. `done_o` is high for that single cycle only and is never high together with `busy_o`.
- R4: Whenever `done_o` is 1, `product_o` equals the 64-bit unsigned product of the operands latched at the accepted start.
- R5: A `start_i` raised while `busy_o` is 1 is ignored, even with different operands on the inputs. The running result and its 32-cycle length are unchanged.
- R6: While the block is idle and `start_i` is low, `product_o` holds its value from one cycle to the next, whatever the operand inputs do.
- R7: A `start_i` presented in the cycle where `done_o` is 1 is accepted and begins a new operation.
- R8: The carry-out of the upper-half addition is kept, so that 0xFFFFFFFF × 0xFFFFFFFF gives 0xFFFFFFFE00000001.
- R9: An operand of 0 gives a product of 0. An operand of 1 gives the other operand, zero-extended.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin a multiplication; honoured only while idle |
| mcand_i | input | 32 | Multiplicand operand |
| mplier_i | input | 32 | Multiplier operand |
| busy_o | output | 1 | An operation is iterating |
| done_o | output | 1 | One-cycle pulse: product is final |
| product_o | output | 64 | Product register contents |

## Verification
The completion pulse and the acceptance of a new start can fall in the same cycle. When `done_o` goes high, the bench raises `start_i` with fresh operands on that same cycle. It then checks three things: `done_o` dropped after one cycle, `busy_o` rose immediately, and the second product is exact and takes 32 cycles. A second collision, a start arriving in the middle of an iteration run, is provoked with changed operands. It is judged by the first result coming out unchanged on schedule.

// File: rtl/mul_seq_pkg.sv
package mul_seq_pkg;

    typedef enum logic {
        PH_IDLE = 1'b0,
        PH_RUN  = 1'b1
    } phase_e;

endpackage

// File: rtl/mul_step_adder.sv
// One iteration's conditional addition: acc + (en ? addend : 0), with carry-out.
module mul_step_adder #(
    parameter int W      = 32,
    parameter bit RIPPLE = 1'b1
) (
    input  logic [W-1:0] acc_i,
    input  logic [W-1:0] addend_i,
    input  logic         en_i,
    output logic [W:0]   sum_o
);

    logic [W-1:0] gated;

    assign gated = en_i ? addend_i : '0;

    generate
        if (RIPPLE) begin : g_ripple
            logic [W:0] carry;
            assign carry[0] = 1'b0;
            for (genvar i = 0; i < W; i++) begin : g_bit
                assign sum_o[i]    = acc_i[i] ^ gated[i] ^ carry[i];
                assign carry[i+1]  = (acc_i[i] & gated[i]) |
                                     (carry[i] & (acc_i[i] ^ gated[i]));
            end
            assign sum_o[W] = carry[W];
        end else begin : g_behav
            assign sum_o = {1'b0, acc_i} + {1'b0, gated};
        end
    endgenerate

endmodule

// File: rtl/mul_iter_ctrl.sv
// Iteration sequencer: accepts start while idle, runs ITERS steps, pulses done.
module mul_iter_ctrl
    import mul_seq_pkg::*;
#(
    parameter int ITERS = 32
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    output logic load_o,
    output logic step_o,
    output logic busy_o,
    output logic done_o
);

    localparam int CW = (ITERS > 1) ? $clog2(ITERS) : 1;
    localparam logic [CW-1:0] LAST = CW'(ITERS - 1);

    typedef struct packed {
        phase_e        phase;
        logic [CW-1:0] cnt;
        logic          done;
    } ctrl_t;

    ctrl_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        load_o    = 1'b0;
        step_o    = 1'b0;
        case (st_q.phase)
            PH_IDLE: begin
                if (start_i) begin
                    load_o     = 1'b1;
                    st_d.phase = PH_RUN;
                    st_d.cnt   = '0;
                end
            end
            PH_RUN: begin
                step_o = 1'b1;
                if (st_q.cnt == LAST) begin
                    st_d.phase = PH_IDLE;
                    st_d.done  = 1'b1;
                    st_d.cnt   = '0;
                end else begin
                    st_d.cnt = st_q.cnt + 1'b1;
                end
            end
            default: st_d.phase = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{phase: PH_IDLE, cnt: '0, done: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign busy_o = (st_q.phase == PH_RUN);
    assign done_o = st_q.done;

endmodule

// File: rtl/mul_prod_reg.sv
// Shared product register: multiplier enters the low half, partial sums the high half.
module mul_prod_reg #(
    parameter int W      = 32,
    parameter bit RIPPLE = 1'b1
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           load_i,
    input  logic           step_i,
    input  logic [W-1:0]   mcand_i,
    input  logic [W-1:0]   mplier_i,
    output logic [2*W-1:0] prod_o
);

    typedef struct packed {
        logic [W-1:0] mcand;
        logic [W-1:0] hi;
        logic [W-1:0] lo;
    } dp_t;

    dp_t        dp_d, dp_q;
    logic [W:0] sum;

    mul_step_adder #(.W(W), .RIPPLE(RIPPLE)) u_add (
        .acc_i    (dp_q.hi),
        .addend_i (dp_q.mcand),
        .en_i     (dp_q.lo[0]),
        .sum_o    (sum)
    );

    always_comb begin
        dp_d = dp_q;
        if (load_i) begin
            dp_d.mcand = mcand_i;
            dp_d.hi    = '0;
            dp_d.lo    = mplier_i;
        end else if (step_i) begin
            // {carry, sum, lo} shifted right one place
            dp_d.hi = sum[W:1];
            dp_d.lo = {sum[0], dp_q.lo[W-1:1]};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dp_q <= '0;
        end else begin
            dp_q <= dp_d;
        end
    end

    assign prod_o = {dp_q.hi, dp_q.lo};

endmodule

// File: rtl/mul_seq_shiftadd.sv
module mul_seq_shiftadd #(
    parameter int W      = 32,
    parameter bit RIPPLE = 1'b1
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           start_i,
    input  logic [W-1:0]   mcand_i,
    input  logic [W-1:0]   mplier_i,
    output logic           busy_o,
    output logic           done_o,
    output logic [2*W-1:0] product_o
);

    localparam int ITERS = W;

    logic load, step;

    mul_iter_ctrl #(.ITERS(ITERS)) u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (start_i),
        .load_o  (load),
        .step_o  (step),
        .busy_o  (busy_o),
        .done_o  (done_o)
    );

    mul_prod_reg #(.W(W), .RIPPLE(RIPPLE)) u_dp (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_i   (load),
        .step_i   (step),
        .mcand_i  (mcand_i),
        .mplier_i (mplier_i),
        .prod_o   (product_o)
    );

endmodule

// File: rtl/mul_seq_chk.sv
module mul_seq_chk #(
    parameter int W = 32
) (
    input logic           clk,
    input logic           rst_n,
    input logic           start_i,
    input logic [W-1:0]   mcand_i,
    input logic [W-1:0]   mplier_i,
    input logic           busy_o,
    input logic           done_o,
    input logic [2*W-1:0] product_o
);

    localparam int LW = $clog2(W) + 2;

    logic [LW-1:0]  run_len;
    logic [W-1:0]   ref_a, ref_b;
    logic [2*W-1:0] ref_p;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_len <= '0;
            ref_a   <= '0;
            ref_b   <= '0;
        end else begin
            run_len <= busy_o ? run_len + 1'b1 : '0;
            if (start_i && !busy_o) begin
                ref_a <= mcand_i;
                ref_b <= mplier_i;
            end
        end
    end

    assign ref_p = {{W{1'b0}}, ref_a} * {{W{1'b0}}, ref_b};

    // R2
    start_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !busy_o) |=> busy_o);

    // R3
    run_length_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_o) |-> (run_len == LW'(W)));

    // R3
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R3
    done_not_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(done_o && busy_o));

    // R4
    product_exact_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (product_o == ref_p));

    // R6
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && !start_i) |=> $stable(product_o));

endmodule

bind mul_seq_shiftadd mul_seq_chk #(.W(W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_i   (start_i),
    .mcand_i   (mcand_i),
    .mplier_i  (mplier_i),
    .busy_o    (busy_o),
    .done_o    (done_o),
    .product_o (product_o)
);

// File: tb/sim_mul_seq_shiftadd.sv
`timescale 1ns/1ps
module sim_mul_seq_shiftadd;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [31:0] mcand_i = '0;
    logic [31:0] mplier_i = '0;
    logic        busy_o, done_o;
    logic [63:0] product_o;

    int n_chk = 0;
    int n_bad = 0;
    int cycles = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    mul_seq_shiftadd u0 (
        .clk(clk), .rst_n(rst_n), .start_i(start_i),
        .mcand_i(mcand_i), .mplier_i(mplier_i),
        .busy_o(busy_o), .done_o(done_o), .product_o(product_o)
    );

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 150000 && !finished) begin
            finished = 1'b1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
            $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    task automatic check(input bit ok, input string req,
                         input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Wait for done with cycle count; returns count of negedges after first busy sample.
    task automatic wait_done(output int cyc, input bit mid_start);
        cyc = 0;
        while (!done_o && cyc < 100) begin
            @(negedge clk);
            cyc++;
            if (mid_start && cyc == 10) begin
                start_i  = 1'b1;
                mcand_i  = 32'h1234_5678;
                mplier_i = 32'h0BAD_F00D;
            end else begin
                start_i = 1'b0;
            end
        end
    endtask

    task automatic run_op(input logic [31:0] a, input logic [31:0] b,
                          input bit mid_start, input string req);
        int cyc;
        logic [63:0] exp;
        exp = {32'd0, a} * {32'd0, b};
        @(negedge clk);
        mcand_i = a; mplier_i = b; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        check(busy_o == 1'b1 && done_o == 1'b0, "R2 busy after start", {63'd0, busy_o}, 64'd1);
        wait_done(cyc, mid_start);
        check(cyc == 32, mid_start ? "R5 run length with ignored start" : "R3 run length",
              64'(cyc), 64'd32);
        check(busy_o == 1'b0, "R3 busy low at done", {63'd0, busy_o}, 64'd0);
        check(product_o == exp, req, product_o, exp);
        @(negedge clk);
        check(done_o == 1'b0, "R3 done single cycle", {63'd0, done_o}, 64'd0);
    endtask

    task automatic t_reset;
        check(busy_o == 1'b0 && done_o == 1'b0, "R1 reset flags",
              {62'd0, busy_o, done_o}, 64'd0);
        check(product_o == 64'd0, "R1 reset product", product_o, 64'd0);
    endtask

    task automatic t_corners;
        run_op(32'd0, 32'hDEAD_BEEF, 1'b0, "R9 zero multiplicand");
        run_op(32'hDEAD_BEEF, 32'd0, 1'b0, "R9 zero multiplier");
        run_op(32'd1, 32'hCAFE_F00D, 1'b0, "R9 one multiplicand");
        run_op(32'h8765_4321, 32'd1, 1'b0, "R9 one multiplier");
        run_op(32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b0, "R8 all-ones carry");
        run_op(32'hFFFF_FFFF, 32'd2, 1'b0, "R8 carry into top");
    endtask

    task automatic t_random;
        for (int i = 0; i < 20; i++) begin
            run_op($urandom, $urandom, 1'b0, "R4 random product");
        end
    endtask

    task automatic t_busy_start;
        run_op(32'h0000_FFFF, 32'h0001_0003, 1'b1, "R5 result unaffected by start while busy");
    endtask

    task automatic t_hold;
        logic [63:0] held;
        run_op(32'h0F0F_0F0F, 32'h7070_7070, 1'b0, "R4 pattern product");
        held = product_o;
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            mcand_i  = $urandom;
            mplier_i = $urandom;
        end
        check(product_o == held, "R6 product held while idle", product_o, held);
        check(busy_o == 1'b0, "R6 still idle", {63'd0, busy_o}, 64'd0);
    endtask

    task automatic t_back_to_back;
        int cyc;
        logic [63:0] e1, e2;
        e1 = 64'h0000_0003 * 64'h0000_0005;
        e2 = 64'hABCD_0123 * 64'h0000_F00F;
        @(negedge clk);
        mcand_i = 32'd3; mplier_i = 32'd5; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        wait_done(cyc, 1'b0);
        check(product_o == e1, "R7 first of pair", product_o, e1);
        mcand_i = 32'hABCD_0123; mplier_i = 32'h0000_F00F; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        check(busy_o == 1'b1 && done_o == 1'b0, "R7 start in done cycle accepted",
              {62'd0, busy_o, done_o}, 64'd2);
        wait_done(cyc, 1'b0);
        check(cyc == 32, "R7 second run length", 64'(cyc), 64'd32);
        check(product_o == e2, "R7 second of pair", product_o, e2);
        @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_corners();
        t_random();
        t_busy_start();
        t_hold();
        t_back_to_back();
        repeat (3) @(negedge clk);
        finished = 1'b1;
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule